// File: doc/BRIEF.md
# Audio Stream Transfer-Progress Interrupt Unit

This block watches the byte-level progress of audio streaming transfers and produces interrupt requests from it. There are two audio channels, and each has a transmit and a receive direction, four directions in all. Software programs a byte total for a direction through a small register interface. Writing that total arms the direction and zeroes its progress counter. Each completed byte is reported by a one-cycle strobe from the data mover. When progress reaches the midpoint of the total, a half-way flag may be raised. When progress reaches the full total, a completion flag may be raised, and the counter then holds until software arms the direction again.

A separate address-error strobe raises an address-error flag. Every flag has its own enable bit, and all enables and flags live in a single control/status word. Software reads that word to find the cause of an interrupt and writes 0 to a flag to clear it. The single interrupt line to the interrupt controller is high while any flag is set and its enable is on.

Top module: `adb_irq_unit`

## Requirements
- R1: After reset, every enable, flag, programmed total and progress value reads 0 and `irq` is low.
- R2: Writing address 1+d (d = 2*channel + 1 for receive, 0 for transmit) loads direction d's byte total, zeroes its progress and arms it if the total is non-zero. Each `byte_done[d]` pulse on an armed direction adds one to its progress, readable at address 5+d. A total of 0 leaves the direction idle.
- R3: The half-way point is total>>1, or the total itself when total>>1 is 0. The pulse that brings progress to that point sets half flag d if half enable d is 1, and does so only once per armed transfer.
- R4: The pulse that brings progress to the total sets completion flag d if completion enable d is 1. Progress then stops, and further pulses are ignored until the next arm.
- R5: A flag whose enable is 0 at its event is not set, and turning the enable on afterwards does not set it.
- R6: A control write clears each flag whose data bit is 0 and leaves each flag whose data bit is 1 unchanged. A hardware set in the same cycle wins over the clear.
- R7: `irq` is high exactly while some flag is 1 and its enable is 1. It stays high until such flags are cleared or masked.
- R8: An `addr_err` pulse sets the address-error flag when the address-error enable is 1.
- R9: Directions are independent: pulses on one direction change no other direction's progress or flags.
- R10: Control word at address 0: bits [3:0] half enables by d, [7:4] half flags, [11:8] completion enables, [15:12] completion flags, bit 16 address-error enable, bit 17 address-error flag. Reads are combinational.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data |
| byte_done | input | 4 | One pulse per byte completed, per direction |
| addr_err | input | 1 | Address-error strobe from the data mover |
| irq | output | 1 | Combined interrupt request |

## Verification
The assertions assume that `byte_done` and `addr_err` are single-cycle strobes sampled at the rising edge. They also assume that the register interface issues at most one write per cycle. The bench therefore drives each strobe for exactly one cycle, with changes made on the falling edge. Collisions are produced only on purpose: one case presents a completing byte pulse together with a control write that clears the flags, to exercise the priority of a hardware set over a software clear.

// File: rtl/adb_irq_pkg.sv
package adb_irq_pkg;

  // Half-way point of a transfer. Collapses onto the total when the total
  // is too small to have a distinct midpoint.
  function automatic logic [31:0] half_point(input logic [31:0] total);
    logic [31:0] h;
    h = total >> 1;
    return (h == 32'd0) ? total : h;
  endfunction

  // Next flag state: keep unless cleared, then OR in enabled hardware sets.
  function automatic logic [7:0] flag_next(input logic [7:0] cur,
                                           input logic [7:0] clr,
                                           input logic [7:0] set);
    return (cur & ~clr) | set;
  endfunction

endpackage

// File: rtl/adb_dir_counter.sv
module adb_dir_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             step,
  output logic [CNT_W-1:0] total_o,
  output logic [CNT_W-1:0] count_o,
  output logic             armed_o,
  output logic             half_ev,
  output logic             all_ev
);
  logic [CNT_W-1:0] total_q, cnt_q, cnt_nx, half_pt;
  logic             armed_q, adv;

  assign cnt_nx  = cnt_q + CNT_W'(1);
  assign half_pt = CNT_W'(adb_irq_pkg::half_point(32'(total_q)));
  assign adv     = step && armed_q && !load;
  assign half_ev = adv && (cnt_nx == half_pt);
  assign all_ev  = adv && (cnt_nx == total_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      total_q <= '0;
      cnt_q   <= '0;
      armed_q <= 1'b0;
    end else if (load) begin
      total_q <= load_val;
      cnt_q   <= '0;
      armed_q <= (load_val != '0);
    end else if (adv) begin
      cnt_q <= cnt_nx;
      if (cnt_nx == total_q) armed_q <= 1'b0;
    end
  end

  assign total_o = total_q;
  assign count_o = cnt_q;
  assign armed_o = armed_q;
endmodule

// File: rtl/adb_flag_bank.sv
module adb_flag_bank #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr,
  input  logic [W-1:0] keep_bits,
  input  logic [W-1:0] ev,
  input  logic [W-1:0] en,
  output logic [W-1:0] flag
);
  logic [7:0] clr8, set8, cur8, nx8;

  assign cur8 = 8'(flag);
  assign clr8 = wr ? 8'(~keep_bits) : 8'd0;
  assign set8 = 8'(ev & en);
  assign nx8  = adb_irq_pkg::flag_next(cur8, clr8, set8);

  always_ff @(posedge clk) begin
    if (!rst_n) flag <= '0;
    else        flag <= nx8[W-1:0];
  end
endmodule

// File: rtl/adb_irq_unit.sv
module adb_irq_unit #(
  parameter int N_CH   = 2,
  parameter int CNT_W  = 16,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic [2*N_CH-1:0] byte_done,
  input  logic              addr_err,
  output logic              irq
);
  localparam int N_DIR  = 2 * N_CH;
  localparam int HE_LO  = 0;
  localparam int HF_LO  = N_DIR;
  localparam int AE_LO  = 2 * N_DIR;
  localparam int AF_LO  = 3 * N_DIR;
  localparam int XE_BIT = 4 * N_DIR;
  localparam int XF_BIT = 4 * N_DIR + 1;

  logic [N_DIR-1:0]            half_en, all_en, half_f, all_f;
  logic [N_DIR-1:0]            half_ev, all_ev, armed, load;
  logic [N_DIR-1:0][CNT_W-1:0] total, cnt;
  logic                        ae_en, ae_f, ctl_wr;
  logic [DATA_W-1:0]           ctl_word;
  wire                         unused_wdata = ^reg_wdata;

  assign ctl_wr = reg_wr && (reg_addr == '0);

  for (genvar d = 0; d < N_DIR; d++) begin : g_dir
    assign load[d] = reg_wr && (reg_addr == ADDR_W'(d + 1));
    adb_dir_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .load(load[d]),
      .load_val(reg_wdata[CNT_W-1:0]), .step(byte_done[d]),
      .total_o(total[d]), .count_o(cnt[d]), .armed_o(armed[d]),
      .half_ev(half_ev[d]), .all_ev(all_ev[d])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      half_en <= '0;
      all_en  <= '0;
      ae_en   <= 1'b0;
    end else if (ctl_wr) begin
      half_en <= reg_wdata[HE_LO +: N_DIR];
      all_en  <= reg_wdata[AE_LO +: N_DIR];
      ae_en   <= reg_wdata[XE_BIT];
    end
  end

  adb_flag_bank #(.W(N_DIR)) u_half (
    .clk(clk), .rst_n(rst_n), .wr(ctl_wr), .keep_bits(reg_wdata[HF_LO +: N_DIR]),
    .ev(half_ev), .en(half_en), .flag(half_f)
  );
  adb_flag_bank #(.W(N_DIR)) u_all (
    .clk(clk), .rst_n(rst_n), .wr(ctl_wr), .keep_bits(reg_wdata[AF_LO +: N_DIR]),
    .ev(all_ev), .en(all_en), .flag(all_f)
  );
  adb_flag_bank #(.W(1)) u_aerr (
    .clk(clk), .rst_n(rst_n), .wr(ctl_wr), .keep_bits(reg_wdata[XF_BIT]),
    .ev(addr_err), .en(ae_en), .flag(ae_f)
  );

  always_comb begin
    ctl_word = '0;
    ctl_word[HE_LO +: N_DIR] = half_en;
    ctl_word[HF_LO +: N_DIR] = half_f;
    ctl_word[AE_LO +: N_DIR] = all_en;
    ctl_word[AF_LO +: N_DIR] = all_f;
    ctl_word[XE_BIT]         = ae_en;
    ctl_word[XF_BIT]         = ae_f;
  end

  always_comb begin
    reg_rdata = '0;
    if (reg_addr == '0) reg_rdata = ctl_word;
    for (int d = 0; d < N_DIR; d++) begin
      if (reg_addr == ADDR_W'(d + 1))         reg_rdata = DATA_W'(total[d]);
      if (reg_addr == ADDR_W'(d + 1 + N_DIR)) reg_rdata = DATA_W'(cnt[d]);
    end
  end

  assign irq = (|(half_f & half_en)) | (|(all_f & all_en)) | (ae_f & ae_en);
endmodule

// File: rtl/adb_irq_chk.sv
module adb_irq_chk #(
  parameter int N_DIR = 4,
  parameter int CNT_W = 16
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic [N_DIR-1:0]            half_en,
  input logic [N_DIR-1:0]            all_en,
  input logic [N_DIR-1:0]            half_f,
  input logic [N_DIR-1:0]            all_f,
  input logic [N_DIR-1:0]            half_ev,
  input logic [N_DIR-1:0]            all_ev,
  input logic [N_DIR-1:0]            armed,
  input logic [N_DIR-1:0]            load,
  input logic [N_DIR-1:0][CNT_W-1:0] cnt,
  input logic                        ae_en,
  input logic                        ae_f,
  input logic                        addr_err,
  input logic                        irq
);
  for (genvar d = 0; d < N_DIR; d++) begin : g_a
    // R5: a half flag only rises if its enable was on
    a_r5_half_needs_en: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(half_f[d]) |-> $past(half_en[d]));
    // R6: an enabled hardware event always lands, even against a clear
    a_r6_hw_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
      (all_ev[d] && all_en[d]) |=> all_f[d]);
    // R4: completion disarms the direction
    a_r4_disarm: assert property (@(posedge clk) disable iff (!rst_n)
      all_ev[d] |=> !armed[d]);
    // R4: an idle direction holds its progress
    a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!armed[d] && !load[d]) |=> $stable(cnt[d]));
    // R3: half event only comes from an armed direction
    a_r3_half_armed: assert property (@(posedge clk) disable iff (!rst_n)
      half_ev[d] |-> armed[d]);
  end
  // R7: the request line needs a set flag behind it
  a_r7_irq_source: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> ((|half_f) || (|all_f) || ae_f));
  // R8: enabled address error sets its flag
  a_r8_aerr_set: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_err && ae_en) |=> ae_f);
endmodule

bind adb_irq_unit adb_irq_chk #(.N_DIR(N_DIR), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .half_en(half_en), .all_en(all_en),
  .half_f(half_f), .all_f(all_f), .half_ev(half_ev), .all_ev(all_ev),
  .armed(armed), .load(load), .cnt(cnt), .ae_en(ae_en), .ae_f(ae_f),
  .addr_err(addr_err), .irq(irq)
);

// File: tb/tb_adb_irq_unit.sv
module tb_adb_irq_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [3:0]  byte_done = '0;
  logic        addr_err = 1'b0;
  logic        irq;
  int          n_chk = 0, n_bad = 0;
  bit          finished = 1'b0;

  localparam logic [31:0] EN_ALL = 32'h0001_0F0F;
  // {dir, total, pulses}
  localparam logic [33:0] VEC [8] = '{
    {2'd0, 16'd10, 16'd4}, {2'd0, 16'd10, 16'd5}, {2'd1, 16'd7, 16'd3},
    {2'd1, 16'd7, 16'd2},  {2'd2, 16'd7, 16'd9},  {2'd3, 16'd1, 16'd1},
    {2'd3, 16'd2, 16'd1},  {2'd2, 16'd16, 16'd16}};

  adb_irq_unit dut (.clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .byte_done(byte_done),
    .addr_err(addr_err), .irq(irq));

  always #5 clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0; reg_addr = '0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk); reg_addr = a; #1 d = reg_rdata;
  endtask

  task automatic pulse(input logic [3:0] m, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); byte_done = m;
      @(negedge clk); byte_done = '0;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    // R1 reset state
    rd(4'd0, r); check("R1 ctl", r, 0);
    rd(4'd2, r); check("R1 total", r, 0);
    rd(4'd7, r); check("R1 progress", r, 0);
    check("R1 irq", {31'd0, irq}, 0);

    // R2 R3 R4 R10 vector table
    foreach (VEC[k]) begin
      int d, t, n, hp;
      logic hf, af;
      d = int'(VEC[k][33:32]); t = int'(VEC[k][31:16]); n = int'(VEC[k][15:0]);
      hp = (t / 2 == 0) ? t : t / 2;
      hf = (n >= hp); af = (n >= t);
      wr(4'd0, EN_ALL);
      wr(4'(1 + d), 32'(t));
      pulse(4'(1 << d), n);
      rd(4'd0, r);
      check("R3 half flag", {31'd0, r[4 + d]}, {31'd0, hf});
      check("R4 all flag", {31'd0, r[12 + d]}, {31'd0, af});
      rd(4'(5 + d), r);
      check("R2 progress", r, 32'((n < t) ? n : t));
      check("R7 irq", {31'd0, irq}, {31'd0, hf | af});
    end

    // R5 disabled enables block the flags
    wr(4'd0, 32'd0);
    wr(4'd1, 32'd4); pulse(4'b0001, 4);
    wr(4'd0, EN_ALL);
    rd(4'd0, r); check("R5 flags stay clear", r, EN_ALL);
    check("R5 irq", {31'd0, irq}, 0);

    // R6 selective clear, R7 persistence
    wr(4'd2, 32'd2); pulse(4'b0010, 2);
    wr(4'd0, EN_ALL | 32'h0000_0020);
    rd(4'd0, r); check("R6 keep half, clear all", r, EN_ALL | 32'h0000_0020);
    check("R7 irq held", {31'd0, irq}, 1);
    wr(4'd0, EN_ALL);
    check("R7 irq dropped", {31'd0, irq}, 0);

    // R6 hardware set beats same-cycle clear
    wr(4'd3, 32'd2); pulse(4'b0100, 1);
    @(negedge clk); byte_done = 4'b0100; reg_wr = 1'b1; reg_addr = 4'd0; reg_wdata = EN_ALL;
    @(negedge clk); byte_done = '0; reg_wr = 1'b0;
    rd(4'd0, r); check("R6 hw wins", r, EN_ALL | 32'h0000_4000);

    // R7 masking by enable
    wr(4'd0, 32'h0001_0B0F | 32'h0000_4000);
    check("R7 masked", {31'd0, irq}, 0);
    wr(4'd0, EN_ALL | 32'h0000_4000);
    check("R7 unmasked", {31'd0, irq}, 1);
    wr(4'd0, EN_ALL);

    // R4 stop after completion
    pulse(4'b0100, 3);
    rd(4'd7, r); check("R4 progress held", r, 2);

    // R9 independence
    wr(4'd1, 32'd6); wr(4'd4, 32'd6);
    pulse(4'b0001, 3);
    rd(4'd8, r); check("R9 other progress", r, 0);
    rd(4'd0, r); check("R9 other flags", r, EN_ALL | 32'h0000_0010);
    wr(4'd0, EN_ALL);

    // R2 zero total stays idle; re-arm zeroes progress
    wr(4'd2, 32'd0); pulse(4'b0010, 2);
    rd(4'd6, r); check("R2 zero total idle", r, 0);
    wr(4'd1, 32'd9);
    rd(4'd5, r); check("R2 re-arm zero", r, 0);

    // R8 address error
    wr(4'd0, 32'h0000_0F0F);
    @(negedge clk); addr_err = 1'b1; @(negedge clk); addr_err = 1'b0;
    rd(4'd0, r); check("R8 disabled", {31'd0, r[17]}, 0);
    wr(4'd0, EN_ALL);
    @(negedge clk); addr_err = 1'b1; @(negedge clk); addr_err = 1'b0;
    rd(4'd0, r); check("R8 set", {31'd0, r[17]}, 1);
    check("R8 irq", {31'd0, irq}, 1);

    finished = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule